// File: doc/BRIEF.md
# DRAM Refresh and Start-up Sequencer

This block keeps a multiplexed-address DRAM alive. Once reset is released it first sits out a power-up pause. It then runs a fixed burst of initialisation refresh cycles and only afterwards declares the memory ready for normal traffic. From that point on an interval timer asks for one refresh slot per period. Each slot is requested from the access controller with `req_o`, and the block waits for `grant_i`. It then drives one complete refresh cycle on the row strobe, the column strobe and, when needed, the address pins.

A parameter selects the refresh style.

- **Column-before-row (internal counter).** The column strobe falls ahead of the row strobe and the memory steps its own hidden row counter. No address is driven.
- **Row-only (external counter).** The block drives an 8-bit row address from its own counter around the falling row strobe, and the column strobe stays high. The counter steps once per cycle and wraps.

Interval slots that cannot be served right away are held in a pending count, so none is lost. If a request stays unserved for too many intervals, a sticky overdue flag is raised. All phase lengths are given in clock cycles. The cycle counts must be at least 1, and `RAS_LOW_CYC` must be larger than `TRAIL_CYC`.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is asserted, `req_o`, `ready_o`, `overdue_o` and `addr_oe_o` are low, `ras_n_o` and `cas_n_o` are high, and `addr_o` is zero.
- R2: `req_o` stays low until exactly `PAUSE_CYC` rising edges after reset release. It is first high after that edge, provided no grant has been given.
- R3: `ready_o` stays low until `INIT_CYCLES` refresh cycles have completed. It rises right after the last of them and then stays high.
- R4: When `USE_CBR` is 1, `cas_n_o` is low for exactly `LEAD_CYC` cycles before `ras_n_o` falls, and stays low for exactly `TRAIL_CYC` cycles after the fall. `addr_oe_o` is never asserted.
- R5: When `USE_CBR` is 0, `addr_oe_o` is high for exactly `LEAD_CYC` cycles before `ras_n_o` falls and for exactly `TRAIL_CYC` cycles after the fall. `cas_n_o` never goes low.
- R6: When `USE_CBR` is 0, the driven row is 0 for the first cycle after reset. It rises by one after every completed refresh cycle and wraps from 255 to 0.
- R7: Within every refresh cycle `ras_n_o` is low for exactly `RAS_LOW_CYC` cycles. Between two falls it is high for at least `RAS_PRE_CYC` cycles.
- R8: Once ready, and with the grant held high, `req_o` rises exactly every `INTERVAL_CYC` cycles.
- R9: While `grant_i` is low, `ras_n_o` and `cas_n_o` are high, `addr_oe_o` is low and `addr_o` is zero, even with a request outstanding.
- R10: Every interval tick that is not yet served adds one to a pending count, which saturates at `PEND_MAX`. When the grant returns, all pending refreshes run back to back before `req_o` drops.
- R11: `overdue_o` rises when `OVERDUE_LIM` interval ticks arrive while a request is already outstanding and no refresh has completed. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grant_i | input | 1 | Bus handed to this block by the access controller |
| req_o | output | 1 | Refresh slot wanted, held for the whole cycle |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| addr_oe_o | output | 1 | Address pins driven by this block |
| addr_o | output | ROW_BITS | Row address for row-only refresh, zero when not driving |
| ready_o | output | 1 | Start-up pause and initial burst both complete |
| overdue_o | output | 1 | Sticky flag: refresh starved for too many intervals |

## Verification
Two instances are exercised, one per refresh style.

The column-first instance is tried with four grant patterns:
- a grant withheld through the pause, which shows the pins stay released while a request waits;
- a grant held steady, which exposes the exact interval spacing;
- a grant withdrawn across several intervals, which separates a backlog that is counted from one that is dropped, and shows when the overdue flag should fire;
- the grant restored, which shows the backlog draining back to back.

The row-only instance runs with a constant grant across more than 256 cycles. This makes the counter wrap and lets the strobe-to-address relation be compared against the column-first ordering.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_LEAD    = 3'd1,
    PH_STROBE  = 3'd2,
    PH_LOW     = 3'd3,
    PH_PRECHG  = 3'd4
  } rfsh_phase_e;

  // Number of clock cycles spent in one phase of a refresh cycle.
  function automatic int unsigned phase_len(rfsh_phase_e ph, int unsigned lead,
                                            int unsigned trail, int unsigned ras_low,
                                            int unsigned prechg);
    case (ph)
      PH_LEAD:   return lead;
      PH_STROBE: return trail;
      PH_LOW:    return ras_low - trail;
      PH_PRECHG: return prechg;
      default:   return 1;
    endcase
  endfunction

  // Saturating up/down step of a counter.
  function automatic int unsigned sat_step(int unsigned cur, logic inc, logic dec,
                                           int unsigned cap);
    int unsigned nxt;
    nxt = cur;
    if (inc && !dec && cur < cap) nxt = cur + 1;
    else if (dec && !inc && cur > 0) nxt = cur - 1;
    return nxt;
  endfunction

  // Increment with wrap inside a field of the given width.
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned bits);
    return (v + 1) & ((1 << bits) - 1);
  endfunction

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int unsigned PAUSE_CYC    = 25000,
  parameter int unsigned INTERVAL_CYC = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic pause_done_o,
  output logic tick_o
);
  localparam int unsigned PW = $clog2(PAUSE_CYC + 1);
  localparam int unsigned IW = $clog2(INTERVAL_CYC + 1);

  logic [PW-1:0] pause_q;
  logic [IW-1:0] ivl_q;

  assign pause_done_o = (pause_q == PW'(PAUSE_CYC));
  assign tick_o       = run_i && (ivl_q == IW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pause_q <= '0;
    else if (!pause_done_o) pause_q <= pause_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ivl_q <= '0;
    else if (!run_i) ivl_q <= '0;
    else if (tick_o) ivl_q <= '0;
    else             ivl_q <= ivl_q + 1'b1;
  end
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned PEND_MAX    = 7,
  parameter int unsigned OVERDUE_LIM = 4,
  localparam int unsigned PEND_W     = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              served_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              overdue_o
);
  localparam int unsigned AGE_W = $clog2(OVERDUE_LIM + 1);

  logic [PEND_W-1:0] pend_q;
  logic [AGE_W-1:0]  age_q, age_n;
  logic              ovd_q;
  logic              stale_tick;

  // A tick that finds an earlier request still waiting.
  assign stale_tick = tick_i && (pend_q != '0);

  always_comb begin
    age_n = age_q;
    if (served_i)
      age_n = '0;
    else if (stale_tick && int'(age_q) < int'(OVERDUE_LIM))
      age_n = age_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      age_q  <= '0;
      ovd_q  <= 1'b0;
    end else begin
      pend_q <= PEND_W'(sat_step(int'(pend_q), tick_i, served_i, PEND_MAX));
      age_q  <= age_n;
      ovd_q  <= ovd_q | (int'(age_n) >= int'(OVERDUE_LIM));
    end
  end

  assign pend_o    = pend_q;
  assign overdue_o = ovd_q;
endmodule

// File: rtl/rfsh_cycle_gen.sv
module rfsh_cycle_gen
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned USE_CBR     = 1,
  parameter int unsigned ROW_BITS    = 8,
  parameter int unsigned LEAD_CYC    = 3,
  parameter int unsigned TRAIL_CYC   = 3,
  parameter int unsigned RAS_LOW_CYC = 15,
  parameter int unsigned RAS_PRE_CYC = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                ras_n_o,
  output logic                cas_n_o,
  output logic                addr_oe_o,
  output logic [ROW_BITS-1:0] row_o
);
  localparam int unsigned CNT_W = $clog2(LEAD_CYC + RAS_LOW_CYC + RAS_PRE_CYC + 1);

  rfsh_phase_e     phase_q, phase_n;
  logic [CNT_W-1:0] cnt_q;
  logic             phase_last;
  logic             lead_win;

  assign phase_last = (int'(cnt_q) + 1 ==
                       int'(phase_len(phase_q, LEAD_CYC, TRAIL_CYC, RAS_LOW_CYC, RAS_PRE_CYC)));

  always_comb begin
    phase_n = phase_q;
    case (phase_q)
      PH_IDLE:   if (start_i)    phase_n = PH_LEAD;
      PH_LEAD:   if (phase_last) phase_n = PH_STROBE;
      PH_STROBE: if (phase_last) phase_n = PH_LOW;
      PH_LOW:    if (phase_last) phase_n = PH_PRECHG;
      PH_PRECHG: if (phase_last) phase_n = PH_IDLE;
      default:                   phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_n;
      if (phase_q == PH_IDLE || phase_n != phase_q) cnt_q <= '0;
      else                                          cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o   = (phase_q != PH_IDLE);
  assign done_o   = (phase_q == PH_PRECHG) && phase_last;
  assign lead_win = (phase_q == PH_LEAD) || (phase_q == PH_STROBE);
  assign ras_n_o  = !((phase_q == PH_STROBE) || (phase_q == PH_LOW));

  generate
    if (USE_CBR != 0) begin : g_cbr
      assign cas_n_o   = !lead_win;
      assign addr_oe_o = 1'b0;
      assign row_o     = '0;
    end else begin : g_ror
      logic [ROW_BITS-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      row_q <= '0;
        else if (done_o) row_q <= ROW_BITS'(wrap_inc(int'(row_q), ROW_BITS));
      end
      assign cas_n_o   = 1'b1;
      assign addr_oe_o = lead_win;
      assign row_o     = row_q;
    end
  endgenerate
endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned USE_CBR      = 1,
  parameter int unsigned ROW_BITS     = 8,
  parameter int unsigned PAUSE_CYC    = 25000,
  parameter int unsigned INTERVAL_CYC = 3900,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned LEAD_CYC     = 3,
  parameter int unsigned TRAIL_CYC    = 3,
  parameter int unsigned RAS_LOW_CYC  = 15,
  parameter int unsigned RAS_PRE_CYC  = 10,
  parameter int unsigned PEND_MAX     = 7,
  parameter int unsigned OVERDUE_LIM  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                grant_i,
  output logic                req_o,
  output logic                ras_n_o,
  output logic                cas_n_o,
  output logic                addr_oe_o,
  output logic [ROW_BITS-1:0] addr_o,
  output logic                ready_o,
  output logic                overdue_o
);
  localparam int unsigned INIT_W = $clog2(INIT_CYCLES + 1);
  localparam int unsigned PEND_W = $clog2(PEND_MAX + 1);

  logic                pause_done;
  logic                ivl_tick;
  logic                cyc_start, cyc_done, cyc_busy;
  logic                ras_int, cas_int, oe_int;
  logic [ROW_BITS-1:0] row_cnt;
  logic [PEND_W-1:0]   pend_cnt;
  logic [INIT_W-1:0]   init_left_q;
  logic                init_want;
  logic                served;

  rfsh_timer #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INTERVAL_CYC(INTERVAL_CYC)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (ready_o),
    .pause_done_o(pause_done),
    .tick_o      (ivl_tick)
  );

  rfsh_backlog #(
    .PEND_MAX   (PEND_MAX),
    .OVERDUE_LIM(OVERDUE_LIM)
  ) u_backlog (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (ivl_tick),
    .served_i (served),
    .pend_o   (pend_cnt),
    .overdue_o(overdue_o)
  );

  rfsh_cycle_gen #(
    .USE_CBR    (USE_CBR),
    .ROW_BITS   (ROW_BITS),
    .LEAD_CYC   (LEAD_CYC),
    .TRAIL_CYC  (TRAIL_CYC),
    .RAS_LOW_CYC(RAS_LOW_CYC),
    .RAS_PRE_CYC(RAS_PRE_CYC)
  ) u_cycle (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (cyc_start),
    .busy_o   (cyc_busy),
    .done_o   (cyc_done),
    .ras_n_o  (ras_int),
    .cas_n_o  (cas_int),
    .addr_oe_o(oe_int),
    .row_o    (row_cnt)
  );

  // Start-up burst bookkeeping.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   init_left_q <= INIT_W'(INIT_CYCLES);
    else if (cyc_done && !ready_o) init_left_q <= init_left_q - 1'b1;
  end

  assign ready_o   = pause_done && (init_left_q == '0);
  assign init_want = pause_done && (init_left_q != '0);
  assign served    = cyc_done && ready_o;

  assign req_o     = cyc_busy || init_want || (pend_cnt != '0);
  assign cyc_start = !cyc_busy && req_o && grant_i;

  // Pins are driven only while the bus is granted.
  assign ras_n_o   = grant_i ? ras_int : 1'b1;
  assign cas_n_o   = grant_i ? cas_int : 1'b1;
  assign addr_oe_o = grant_i && oe_int;
  assign addr_o    = addr_oe_o ? row_cnt : '0;
endmodule

// File: rtl/rfsh_seq_checker.sv
module rfsh_seq_checker #(
  parameter int unsigned CBR_MODE = 1,
  parameter int unsigned ROW_BITS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                grant_i,
  input logic                req_o,
  input logic                ras_n_o,
  input logic                cas_n_o,
  input logic                addr_oe_o,
  input logic                ready_o,
  input logic                overdue_o,
  input logic                pause_done,
  input logic                cyc_done,
  input logic [ROW_BITS-1:0] row_cnt
);
  localparam logic IS_CBR = (CBR_MODE != 0);

  p_no_req_in_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_done |-> !req_o);

  p_ready_after_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(cyc_done));

  p_ready_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);

  p_cas_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_CBR && $fell(ras_n_o)) |-> !cas_n_o);

  p_cbr_no_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    IS_CBR |-> !addr_oe_o);

  p_ror_cas_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !IS_CBR |-> cas_n_o);

  p_ror_addr_at_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_CBR && $fell(ras_n_o)) |-> addr_oe_o);

  p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_CBR && cyc_done) |=> (row_cnt == ($past(row_cnt) + 1'b1)));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_i |-> (ras_n_o && cas_n_o && !addr_oe_o));

  p_overdue_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    overdue_o |=> overdue_o);
endmodule

bind dram_rfsh_seq rfsh_seq_checker #(
  .CBR_MODE(USE_CBR),
  .ROW_BITS(ROW_BITS)
) u_rfsh_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .grant_i   (grant_i),
  .req_o     (req_o),
  .ras_n_o   (ras_n_o),
  .cas_n_o   (cas_n_o),
  .addr_oe_o (addr_oe_o),
  .ready_o   (ready_o),
  .overdue_o (overdue_o),
  .pause_done(pause_done),
  .cyc_done  (cyc_done),
  .row_cnt   (row_cnt)
);

// File: tb/tb_dram_rfsh_seq.sv
module tb_dram_rfsh_seq;
  // Instance A: column-first refresh; instance B: row-only refresh.
  localparam int P_A = 40, I_A = 120, LEAD_A = 3, TRAIL_A = 3;
  localparam int P_B = 20, I_B = 40,  LEAD_B = 2, TRAIL_B = 4;
  localparam int RASL = 15, PRE = 10, INIT = 8, LIM = 2, PMAX = 7;

  // Row-only expectation table: {cycle index, expected row}.
  localparam int VEC_N = 8;
  localparam logic [16:0] VEC [VEC_N] = '{
    {9'd0, 8'd0}, {9'd1, 8'd1}, {9'd7, 8'd7}, {9'd8, 8'd8},
    {9'd100, 8'd100}, {9'd255, 8'd255}, {9'd256, 8'd0}, {9'd257, 8'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic g_a = 1'b0, g_b = 1'b1;
  logic req_a, ras_a, cas_a, oe_a, rdy_a, ovd_a;
  logic req_b, ras_b, cas_b, oe_b, rdy_b, ovd_b;
  logic [7:0] addr_a, addr_b;

  int nchk = 0, nfail = 0, cyc = 0;
  bit timeout = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_rfsh_seq #(
    .USE_CBR(1), .ROW_BITS(8), .PAUSE_CYC(P_A), .INTERVAL_CYC(I_A), .INIT_CYCLES(INIT),
    .LEAD_CYC(LEAD_A), .TRAIL_CYC(TRAIL_A), .RAS_LOW_CYC(RASL), .RAS_PRE_CYC(PRE),
    .PEND_MAX(PMAX), .OVERDUE_LIM(LIM)
  ) dut (
    .clk(clk), .rst_n(rst_n), .grant_i(g_a), .req_o(req_a), .ras_n_o(ras_a),
    .cas_n_o(cas_a), .addr_oe_o(oe_a), .addr_o(addr_a), .ready_o(rdy_a), .overdue_o(ovd_a)
  );

  dram_rfsh_seq #(
    .USE_CBR(0), .ROW_BITS(8), .PAUSE_CYC(P_B), .INTERVAL_CYC(I_B), .INIT_CYCLES(INIT),
    .LEAD_CYC(LEAD_B), .TRAIL_CYC(TRAIL_B), .RAS_LOW_CYC(RASL), .RAS_PRE_CYC(PRE),
    .PEND_MAX(PMAX), .OVERDUE_LIM(LIM)
  ) dut_ro (
    .clk(clk), .rst_n(rst_n), .grant_i(g_b), .req_o(req_b), .ras_n_o(ras_b),
    .cas_n_o(cas_b), .addr_oe_o(oe_b), .addr_o(addr_b), .ready_o(rdy_b), .overdue_o(ovd_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor of instance A, sampled on the falling edge.
  int a_lead = 0, a_trail = 0, a_low = 0, a_high = 0, a_falls = 0;
  bit a_pras = 1, a_pcas = 1, a_prdy = 0, a_oe_seen = 0;
  always @(negedge clk) if (rst_n) begin
    if (a_pras && !ras_a) begin
      check(a_lead == LEAD_A, "R4 cas lead before ras fall", a_lead, LEAD_A);
      if (a_falls > 0) check(a_high >= PRE, "R7 ras precharge", a_high, PRE);
      a_falls++; a_low = 0; a_trail = 0; a_high = 0;
    end
    if (!a_pras && ras_a) check(a_low == RASL, "R7 ras low width", a_low, RASL);
    if (!a_pras && !ras_a && !a_pcas && cas_a)
      check(a_trail == TRAIL_A, "R4 cas hold after ras fall", a_trail, TRAIL_A);
    if (!a_prdy && rdy_a) check(a_falls == INIT, "R3 cycles before ready", a_falls, INIT);
    if (ras_a) a_high++; else a_low++;
    a_lead  = (ras_a && !cas_a) ? a_lead + 1 : 0;
    if (!ras_a && !cas_a) a_trail++;
    if (oe_a) a_oe_seen = 1;
    a_pras = ras_a; a_pcas = cas_a; a_prdy = rdy_a;
  end

  // Monitor of instance B.
  int b_lead = 0, b_trail = 0, b_low = 0, b_falls = 0;
  bit b_pras = 1, b_poe = 0, b_cas_seen = 0;
  logic [7:0] rows [0:299];
  always @(negedge clk) if (rst_n) begin
    if (b_pras && !ras_b) begin
      check(b_lead == LEAD_B, "R5 address lead before ras fall", b_lead, LEAD_B);
      if (b_falls < 300) rows[b_falls] = addr_b;
      b_falls++; b_low = 0; b_trail = 0;
    end
    if (!b_pras && ras_b) check(b_low == RASL, "R7 ras low width (row-only)", b_low, RASL);
    if (!ras_b && b_poe && !oe_b)
      check(b_trail == TRAIL_B, "R5 address hold after ras fall", b_trail, TRAIL_B);
    if (!ras_b) b_low++;
    b_lead = (ras_b && oe_b) ? b_lead + 1 : 0;
    if (!ras_b && oe_b) b_trail++;
    if (!cas_b) b_cas_seen = 1;
    b_pras = ras_b; b_poe = oe_b;
  end

  task automatic wait_req_rise(output int t);
    bit prev;
    prev = req_a;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (!prev && req_a) break;
      prev = req_a;
    end
    t = cyc;
  endtask

  task automatic run_main();
    int t1, t2, t3, t0, f0;
    // R1: reset state
    repeat (4) @(negedge clk);
    check(req_a == 0 && req_b == 0, "R1 req low in reset", int'(req_a), 0);
    check(ras_a && cas_a && ras_b && cas_b, "R1 strobes high in reset", int'(ras_a & cas_a), 1);
    check(!rdy_a && !ovd_a && !oe_a && !oe_b, "R1 flags low in reset", int'(rdy_a | ovd_a | oe_a), 0);
    check(addr_b == 0, "R1 address zero in reset", int'(addr_b), 0);
    rst_n = 1'b1;
    // R2: exact pause length
    for (int k = 1; k <= P_A; k++) begin
      @(negedge clk);
      if (k == P_A - 1) check(req_a == 0, "R2 req low before pause end", int'(req_a), 0);
      if (k == P_A)     check(req_a == 1, "R2 req high at pause end", int'(req_a), 1);
    end
    // R9: request pending, grant withheld
    repeat (3) @(negedge clk);
    check(ras_a && cas_a, "R9 strobes released without grant", int'(ras_a & cas_a), 1);
    check(!oe_a && addr_a == 0, "R9 address released without grant", int'(addr_a), 0);
    check(req_a == 1, "R9 request held while waiting", int'(req_a), 1);
    check(rdy_a == 0, "R3 not ready before burst", int'(rdy_a), 0);
    g_a = 1'b1;
    for (int k = 0; k < 2000 && !rdy_a; k++) @(negedge clk);
    check(rdy_a == 1, "R3 ready after burst", int'(rdy_a), 1);
    // R8: interval spacing
    wait_req_rise(t1);
    wait_req_rise(t2);
    wait_req_rise(t3);
    check(t2 - t1 == I_A, "R8 interval spacing", t2 - t1, I_A);
    check(t3 - t2 == I_A, "R8 interval spacing", t3 - t2, I_A);
    // R11/R10: starve, then restore
    for (int k = 0; k < 500 && req_a; k++) @(negedge clk);
    g_a = 1'b0;
    t0 = cyc;
    for (int k = 0; k < 1000 && !ovd_a; k++) @(negedge clk);
    check(ovd_a && (cyc - t0) > 2 * I_A && (cyc - t0) <= 3 * I_A,
          "R11 overdue after limit intervals", cyc - t0, 3 * I_A);
    f0 = a_falls;
    g_a = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 500 && req_a; k++) @(negedge clk);
    check(a_falls - f0 == 3, "R10 backlog served back to back", a_falls - f0, 3);
    check(req_a == 0, "R10 request drops after backlog", int'(req_a), 0);
    check(ovd_a == 1, "R11 overdue sticky", int'(ovd_a), 1);
    // R6: row-only counter sequence and wrap
    for (int k = 0; k < 20000 && b_falls < 260; k++) @(negedge clk);
    check(b_falls >= 260, "R6 row-only cycles seen", b_falls, 260);
    for (int v = 0; v < VEC_N; v++)
      check(rows[int'(VEC[v][16:8])] == VEC[v][7:0], "R6 row sequence",
            int'(rows[int'(VEC[v][16:8])]), int'(VEC[v][7:0]));
    check(a_oe_seen == 0, "R4 no address in column-first mode", int'(a_oe_seen), 0);
    check(b_cas_seen == 0, "R5 column strobe stays high", int'(b_cas_seen), 0);
    check(rdy_b == 1 && ovd_b == 0, "R3 row-only ready, never overdue", int'(rdy_b), 1);
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) check(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule